// File: doc/BRIEF.md
# Data-Side Address Translation Buffer

This block translates data virtual addresses into physical addresses on behalf of a load/store pipeline. Virtual addresses are 43 bits wide and physical addresses 34 bits wide. Pages are 8 KB, so the low 13 bits of an address are the byte offset and pass through untouched. The upper 30 bits, the virtual page number, are compared against the tags of all 32 entries in the same cycle. Every entry holds a tag, a 21-bit frame number, a valid bit and four access enables: read and write for kernel mode, and read and write for user mode.

A lookup presents an address, a read/write flag and a privilege-mode flag. One cycle later the block reports exactly one outcome. A hit returns the translated address. A miss means no valid entry matched. A fault means an entry matched but its enable for the current mode and access is clear, and in that case no address is released. Entries are loaded through a fill port that picks its own slot. A flush input invalidates the whole array in a single cycle. Page-table walking and fault handling sit outside the block.

Top module: `xlat_buffer`

## Requirements
- R1: After reset no response is flagged, every entry is invalid and the replacement pointer is at entry 0. The first lookup therefore reports a miss.
- R2: A lookup accepted on one rising edge produces its response on the next rising edge, with `rsp_valid` high and exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` set. Back-to-back lookups give back-to-back responses.
- R3: A lookup whose bits [42:13] match the tag of no valid entry reports a miss with `rsp_pa` equal to zero.
- R4: On a hit, `rsp_pa` is the matching entry's 21-bit frame number in bits [33:13], joined with the request's bits [12:0] unchanged.
- R5: `fill_perm` is encoded as bit 0 kernel read, bit 1 kernel write, bit 2 user read and bit 3 user write. `req_user`=1 selects user mode and `req_write`=1 selects a write. A match whose selected enable is clear reports a fault with `rsp_pa` equal to zero.
- R6: A fill goes to the lowest-numbered invalid entry when one exists, so no valid entry is overwritten while free entries remain.
- R7: When all entries are valid, a fill replaces the entry named by a wrapping round-robin pointer, and the pointer then moves to the next index. The pointer moves only on such replacements, and reset or flush returns it to 0.
- R8: A flush invalidates every entry within one cycle and resets the pointer. A fill in the same cycle as a flush is discarded. A lookup in the flush cycle still sees the contents from before the flush.
- R9: If more than one valid entry holds the same tag, the lowest-numbered one supplies the result.
- R10: A fill takes effect for lookups from the following cycle. A lookup in the same cycle as the fill sees the old contents.
- R11: While `rsp_valid` is low, `rsp_hit`, `rsp_miss`, `rsp_fault` and `rsp_pa` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 43 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| fill_valid | input | 1 | Write a new entry |
| fill_vpn | input | 30 | Tag for the new entry |
| fill_pfn | input | 21 | Frame number for the new entry |
| fill_perm | input | 4 | Access enables for the new entry (see R5) |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_fault | output | 1 | Entry matched but access is not permitted |
| rsp_pa | output | 34 | Physical address on a hit, zero otherwise |

## Verification
On every cycle, the embedded assertions check the one-cycle response timing, the single-outcome rule and zero outputs when idle. They also check that the page offset passes through on hits, that faults and misses release no address, that no lookup can hit right after a flush, that the select vector has at most one bit set, and that the pointer holds still without a replacing fill. Only the bench scenarios can show which entry a fill actually lands in, that the round-robin order wraps through the array, that duplicate tags resolve to the lowest index, and that each mode and access combination picks the right enable bit. These properties depend on sequences of fills followed by lookups whose outcome reveals the stored contents.

// File: rtl/xb_pkg.sv
package xb_pkg;

   // Access enables; packed so that bit index == {user, write}
   typedef struct packed {
      logic usr_wr;   // bit 3
      logic usr_rd;   // bit 2
      logic krn_wr;   // bit 1
      logic krn_rd;   // bit 0
   } xb_perm_t;

   localparam int XB_PERM_W = $bits(xb_perm_t);

   function automatic logic [1:0] xb_access_sel(input logic user, input logic write);
      return {user, write};
   endfunction

endpackage

// File: rtl/xb_cam.sv
module xb_cam #(
   parameter int ENTRIES = 32,
   parameter int TAG_W   = 30,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ENTRIES-1:0]         ent_valid,
   input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
   input  logic [TAG_W-1:0]           look_tag,
   output logic                       any_match,
   output logic [IDX_W-1:0]           sel_idx
);

   logic [ENTRIES-1:0] match_vec;
   logic [ENTRIES-1:0] sel_oh;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = ent_valid[g] && (ent_tag[g] == look_tag);
   end

   // isolate the lowest set bit: lowest index wins on duplicates
   assign sel_oh    = match_vec & (~match_vec + ENTRIES'(1));
   assign any_match = |match_vec;

   always_comb begin
      sel_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (sel_oh[i]) sel_idx = sel_idx | IDX_W'(i);
      end
   end

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_oh)) else $error("select vector not one-hot"); // R9
   AST_SEL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      (match_vec != '0) |-> (sel_oh != '0)) else $error("match without select"); // R9

endmodule

// File: rtl/xb_perm_chk.sv
module xb_perm_chk
   import xb_pkg::*;
#(
   parameter bit CHECK_EN = 1'b1
) (
   input  xb_perm_t perm,
   input  logic     is_user,
   input  logic     is_write,
   output logic     allow
);

   if (CHECK_EN) begin : g_check
      logic [XB_PERM_W-1:0] perm_bits;
      assign perm_bits = perm;
      assign allow     = perm_bits[xb_access_sel(is_user, is_write)];
   end else begin : g_open
      logic unused_ok;
      assign unused_ok = ^{perm, is_user, is_write};
      assign allow     = 1'b1;
   end

endmodule

// File: rtl/xb_victim.sv
module xb_victim #(
   parameter int ENTRIES = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] ent_valid,
   input  logic               fill_en,
   input  logic               flush,
   output logic [IDX_W-1:0]   victim_idx
);

   logic [IDX_W-1:0] rr_ptr_q;
   logic [IDX_W-1:0] free_idx;
   logic             have_free;

   always_comb begin
      free_idx  = '0;
      have_free = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!ent_valid[i]) begin
            free_idx  = IDX_W'(i);
            have_free = 1'b1;
         end
      end
   end

   assign victim_idx = have_free ? free_idx : rr_ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_ptr_q <= '0;
      end else if (flush) begin
         rr_ptr_q <= '0;
      end else if (fill_en && !have_free) begin
         rr_ptr_q <= rr_ptr_q + IDX_W'(1);
      end
   end

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!fill_en && !flush) |=> $stable(rr_ptr_q)) else $error("pointer moved without fill"); // R7
   AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      have_free |-> !ent_valid[victim_idx]) else $error("victim is a live entry"); // R6

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
   import xb_pkg::*;
#(
   parameter int VA_W      = 43,
   parameter int PA_W      = 34,
   parameter int PAGE_BITS = 13,
   parameter int ENTRIES   = 32,
   parameter bit PERM_EN   = 1'b1,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PFN_W    = PA_W - PAGE_BITS,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_write,
   input  logic             req_user,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic [3:0]       fill_perm,
   input  logic             flush,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_miss,
   output logic             rsp_fault,
   output logic [PA_W-1:0]  rsp_pa
);

   // elaboration-time parameter checks
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (PAGE_BITS < 1 || VA_W <= PAGE_BITS || PA_W <= PAGE_BITS) begin : g_bad_widths
      $error("address widths must exceed the page offset width");
   end

   // entry storage
   logic [ENTRIES-1:0]            valid_q;
   logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
   logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
   xb_perm_t [ENTRIES-1:0]        perm_q;

   logic [IDX_W-1:0] victim_idx;
   logic             fill_en;

   assign fill_en = fill_valid && !flush;

   xb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .ent_valid  (valid_q),
      .fill_en    (fill_en),
      .flush      (flush),
      .victim_idx (victim_idx)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            tag_q[g]   <= '0;
            pfn_q[g]   <= '0;
            perm_q[g]  <= '0;
         end else if (flush) begin
            valid_q[g] <= 1'b0;
         end else if (fill_en && victim_idx == IDX_W'(g)) begin
            valid_q[g] <= 1'b1;
            tag_q[g]   <= fill_vpn;
            pfn_q[g]   <= fill_pfn;
            perm_q[g]  <= xb_perm_t'(fill_perm);
         end
      end
   end

   // lookup path: compare, permission check, frame select, join
   logic [VPN_W-1:0]     look_vpn;
   logic [PAGE_BITS-1:0] look_ofs;
   logic                 any_match;
   logic [IDX_W-1:0]     sel_idx;
   logic                 allow;
   xb_perm_t             sel_perm;
   logic [PFN_W-1:0]     sel_pfn;

   assign look_vpn = req_va[VA_W-1:PAGE_BITS];
   assign look_ofs = req_va[PAGE_BITS-1:0];

   xb_cam #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_cam (
      .clk       (clk),
      .rst_n     (rst_n),
      .ent_valid (valid_q),
      .ent_tag   (tag_q),
      .look_tag  (look_vpn),
      .any_match (any_match),
      .sel_idx   (sel_idx)
   );

   assign sel_perm = perm_q[sel_idx];
   assign sel_pfn  = pfn_q[sel_idx];

   xb_perm_chk #(.CHECK_EN(PERM_EN)) u_perm (
      .perm     (sel_perm),
      .is_user  (req_user),
      .is_write (req_write),
      .allow    (allow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_pa    <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && any_match && allow;
         rsp_fault <= req_valid && any_match && !allow;
         rsp_miss  <= req_valid && !any_match;
         rsp_pa    <= (req_valid && any_match && allow) ? {sel_pfn, look_ofs} : '0;
      end
   end

   AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid) else $error("response not one cycle after request"); // R2
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1)) else $error("outcome not unique"); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault && rsp_pa == '0)) else $error("idle outputs active"); // R11
   AST_OFS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!rsp_hit || rsp_pa[PAGE_BITS-1:0] == $past(look_ofs))) else $error("offset altered"); // R4
   AST_NO_PA_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault || rsp_miss) |-> (rsp_pa == '0)) else $error("address leaked"); // R5
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (flush ##1 req_valid) |=> rsp_miss) else $error("hit right after flush"); // R8

endmodule

// File: tb/tb_xlat_buffer.sv
`timescale 1ns/1ps
module tb_xlat_buffer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [42:0] req_va = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        fill_valid = 1'b0;
   logic [29:0] fill_vpn = '0;
   logic [20:0] fill_pfn = '0;
   logic [3:0]  fill_perm = '0;
   logic        flush = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
   logic [33:0] rsp_pa;

   always #2 clk = ~clk;   // 250 MHz

   xlat_buffer dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_user(req_user),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
      .flush(flush),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
      .rsp_pa(rsp_pa)
   );

   typedef struct {
      logic        hit;
      logic        miss;
      logic        fault;
      logic [33:0] pa;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done     = 1'b0;

   localparam int K_HIT = 0, K_MISS = 1, K_FAULT = 2;

   function automatic exp_t mk_exp(int kind, logic [20:0] pfn, logic [12:0] ofs, string req);
      exp_t e;
      e.hit   = (kind == K_HIT);
      e.miss  = (kind == K_MISS);
      e.fault = (kind == K_FAULT);
      e.pa    = (kind == K_HIT) ? {pfn, ofs} : 34'd0;
      e.req   = req;
      return e;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_checks++;
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               n_fails++;
               $display("FAIL R2: unexpected response hit=%0b miss=%0b fault=%0b, expected none",
                        rsp_hit, rsp_miss, rsp_fault);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               if (rsp_hit !== e.hit || rsp_miss !== e.miss || rsp_fault !== e.fault || rsp_pa !== e.pa) begin
                  n_fails++;
                  $display("FAIL %s: got h/m/f=%0b%0b%0b pa=%h, expected h/m/f=%0b%0b%0b pa=%h",
                           e.req, rsp_hit, rsp_miss, rsp_fault, rsp_pa, e.hit, e.miss, e.fault, e.pa);
               end
            end
         end else if (rsp_hit || rsp_miss || rsp_fault || rsp_pa != '0) begin
            n_fails++;
            $display("FAIL R11: idle outputs h/m/f=%0b%0b%0b pa=%h, expected all zero",
                     rsp_hit, rsp_miss, rsp_fault, rsp_pa);
         end
      end
   end

   // driver tasks
   task automatic set_req(logic [29:0] vpn, logic [12:0] ofs, bit wr, bit usr,
                          int kind, logic [20:0] pfn, string req);
      exp_q.push_back(mk_exp(kind, pfn, ofs, req));
      req_valid = 1'b1;
      req_va    = {vpn, ofs};
      req_write = wr;
      req_user  = usr;
   endtask

   task automatic lookup(logic [29:0] vpn, logic [12:0] ofs, bit wr, bit usr,
                         int kind, logic [20:0] pfn, string req);
      @(negedge clk);
      set_req(vpn, ofs, wr, usr, kind, pfn, req);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic fill(logic [29:0] vpn, logic [20:0] pfn, logic [3:0] perm);
      @(negedge clk);
      fill_valid = 1'b1;
      fill_vpn   = vpn;
      fill_pfn   = pfn;
      fill_perm  = perm;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      n_checks++;
      if (rsp_valid || rsp_hit || rsp_miss || rsp_fault || rsp_pa != '0) begin
         n_fails++;
         $display("FAIL R1: reset outputs v=%0b pa=%h, expected 0", rsp_valid, rsp_pa);
      end
      lookup(30'd5, 13'h0AB, 0, 0, K_MISS, '0, "R1");
      lookup(30'h1234, 13'h000, 0, 1, K_MISS, '0, "R3");

      // R4: basic hit with several offsets
      fill(30'h1234, 21'h0ABCDE & 21'h1FFFFF, 4'b1111);
      lookup(30'h1234, 13'h000, 0, 0, K_HIT, 21'h0ABCDE, "R4");
      lookup(30'h1234, 13'h1FFF, 1, 1, K_HIT, 21'h0ABCDE, "R4");
      lookup(30'h1235, 13'h010, 0, 0, K_MISS, '0, "R3");

      // R2: back-to-back lookups
      @(negedge clk);
      set_req(30'h1234, 13'h055, 0, 0, K_HIT, 21'h0ABCDE, "R2");
      @(negedge clk);
      set_req(30'h9999, 13'h055, 0, 0, K_MISS, '0, "R2");
      @(negedge clk);
      set_req(30'h1234, 13'h1AA, 0, 1, K_HIT, 21'h0ABCDE, "R2");
      @(negedge clk);
      req_valid = 1'b0;

      // R10: fill and lookup of same page in one cycle
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = 30'h77; fill_pfn = 21'h00777; fill_perm = 4'b1111;
      set_req(30'h77, 13'h003, 0, 0, K_MISS, '0, "R10");
      @(negedge clk);
      fill_valid = 1'b0; req_valid = 1'b0;
      lookup(30'h77, 13'h003, 0, 0, K_HIT, 21'h00777, "R10");

      // R5: permission encoding
      fill(30'h200, 21'h00011, 4'b0001);
      lookup(30'h200, 13'h004, 0, 0, K_HIT,   21'h00011, "R5");
      lookup(30'h200, 13'h004, 1, 0, K_FAULT, '0, "R5");
      lookup(30'h200, 13'h004, 0, 1, K_FAULT, '0, "R5");
      lookup(30'h200, 13'h004, 1, 1, K_FAULT, '0, "R5");
      fill(30'h201, 21'h00022, 4'b1000);
      lookup(30'h201, 13'h008, 1, 1, K_HIT,   21'h00022, "R5");
      lookup(30'h201, 13'h008, 0, 1, K_FAULT, '0, "R5");
      lookup(30'h201, 13'h008, 1, 0, K_FAULT, '0, "R5");
      fill(30'h202, 21'h00033, 4'b0110);
      lookup(30'h202, 13'h00C, 1, 0, K_HIT,   21'h00033, "R5");
      lookup(30'h202, 13'h00C, 0, 1, K_HIT,   21'h00033, "R5");
      lookup(30'h202, 13'h00C, 0, 0, K_FAULT, '0, "R5");

      // R9: duplicate tag lands in a higher entry, lower one wins
      fill(30'h1234, 21'h12222, 4'b1111);
      lookup(30'h1234, 13'h100, 0, 0, K_HIT, 21'h0ABCDE, "R9");

      // R8: flush with concurrent fill and lookup
      @(negedge clk);
      flush = 1'b1;
      fill_valid = 1'b1; fill_vpn = 30'h300; fill_pfn = 21'h00300; fill_perm = 4'b1111;
      set_req(30'h1234, 13'h020, 0, 0, K_HIT, 21'h0ABCDE, "R8");
      @(negedge clk);
      flush = 1'b0; fill_valid = 1'b0;
      set_req(30'h1234, 13'h020, 0, 0, K_MISS, '0, "R8");
      @(negedge clk);
      req_valid = 1'b0;
      lookup(30'h300, 13'h020, 0, 0, K_MISS, '0, "R8");
      lookup(30'h77, 13'h020, 0, 0, K_MISS, '0, "R8");

      // R6: fill all entries, none overwritten
      for (int i = 0; i < 32; i++) fill(30'h400 + 30'(i), 21'h01000 + 21'(i), 4'b1111);
      for (int i = 0; i < 32; i++) lookup(30'h400 + 30'(i), 13'(i), 0, 0, K_HIT, 21'h01000 + 21'(i), "R6");

      // R7: round-robin replacement from entry 0
      fill(30'h500, 21'h00005, 4'b1111);
      lookup(30'h400, 13'h0, 0, 0, K_MISS, '0, "R7");
      lookup(30'h500, 13'h0, 0, 0, K_HIT, 21'h00005, "R7");
      lookup(30'h401, 13'h0, 0, 0, K_HIT, 21'h01001, "R7");
      fill(30'h501, 21'h00006, 4'b1111);
      lookup(30'h401, 13'h0, 0, 0, K_MISS, '0, "R7");
      lookup(30'h501, 13'h0, 0, 0, K_HIT, 21'h00006, "R7");
      lookup(30'h402, 13'h0, 0, 0, K_HIT, 21'h01002, "R7");

      repeat (4) @(negedge clk);
      n_checks++;
      if (exp_q.size() != 0) begin
         n_fails++;
         $display("FAIL R2: %0d responses missing, expected 0", exp_q.size());
      end
      finish_run();
   end

endmodule